// File: doc/BRIEF.md
# Programmable PLL Channel Clock Divider

This block turns the fast output of a PLL into a slower, gated clock for one channel of that PLL. The ratio is the product of two numbers. One is an integer field in the channel's own control word. The other is a fixed post-divider that each instance sets as a parameter. The block runs on the parent clock and gives two outputs: a one-cycle clock-enable pulse once per output period, and a divided square-ish level. It also gives a flag that shows whether the channel is producing a clock.

There are two ways to stop the channel. One is a disable bit in the channel control word. The other is a hold bit that belongs to this channel inside a control word shared by every channel of the same PLL; a per-instance mask selects it. When the channel is stopped, both outputs stay low, so downstream logic sees no clock at all. Because the shared word is an input on every cycle, any change to it affects every attached channel at once.

A new ratio is taken only at the end of the current output period, so no short period is ever produced. After reset, and each time the channel starts, the first full period passes with the level output held low.

Top module: `pll_chan_div`

## Requirements
- R1: While reset is asserted, and while the channel is stopped after reset, `clk_en`, `clk_out` and `running` are all 0.
- R2: When bit DIV_W (bit 8 by default) of `chan_ctrl` is 1 at a clock edge, all three outputs are 0 after that edge.
- R3: When `pll_ctrl` has any bit set that is also set in HOLD_MASK, all three outputs are 0 after that edge. Bits of `pll_ctrl` outside HOLD_MASK have no effect on the period or on the outputs.
- R4: The divide field is `chan_ctrl[DIV_W-1:0]`. While running, `clk_en` pulses once every N = DIV × FIXED_DIV parent cycles.
- R5: A divide field of 0 acts as the largest value the field can hold (255 by default), so N = 255 × FIXED_DIV.
- R6: Within each period, `clk_out` is high for the first floor(N/2) cycles and low for the rest, so for odd N the high phase is one cycle shorter than the low phase. `clk_out` rises only in a cycle where `clk_en` is high.
- R7: When the channel starts, the first `clk_en` comes N cycles after the first edge at which the channel is enabled. `clk_out` stays low until that pulse.
- R8: A change of the divide field during a period does not change that period's length. The new N applies from the next period on.
- R9: `running` is 1 after every edge at which neither the disable bit nor a masked hold bit is set.
- R10: Bits of `chan_ctrl` above the disable bit have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent PLL output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_ctrl | input | 32 | Channel control word: divide field and disable bit |
| pll_ctrl | input | 32 | Shared PLL control word holding the channel hold bits |
| clk_en | output | 1 | One-cycle pulse at the start of each output period |
| clk_out | output | 1 | Divided clock level |
| running | output | 1 | High while the channel is producing a clock |

## Verification
Some behaviour is checked by assertions on every cycle. They check that the disable bit and the hold bit stop the channel one edge later, that an open gate raises `running`, and that the outputs stay quiet while stopped. They also check that `clk_out` rises only together with `clk_en` and stays low in the cycle the channel starts. Other behaviour only the bench scenarios can show. These are the exact period lengths, including the zero-means-maximum case and odd ratios with their short high phase. They also include the deferral of a mid-period ratio change to the next boundary, and the fact that unrelated control bits are ignored. A behavioural reference model is compared with the outputs on every cycle.

// File: rtl/pllch_pkg.sv
package pllch_pkg;
    localparam int unsigned CTRL_W = 32;
    typedef logic [CTRL_W-1:0] ctrl_word_t;
endpackage

// File: rtl/pllch_decode.sv
module pllch_decode
    import pllch_pkg::*;
#(
    parameter int unsigned DIV_W     = 8,
    parameter int unsigned FIXED_DIV = 2,
    parameter logic [31:0] HOLD_MASK = 32'h0000_0200,
    parameter int unsigned RATIO_W   = 10
) (
    input  ctrl_word_t         chan_ctrl,
    input  ctrl_word_t         pll_ctrl,
    output logic               gate,
    output logic [RATIO_W-1:0] ratio
);
    localparam int unsigned DIS_POS = DIV_W;

    logic [DIV_W-1:0] div_raw;
    logic [DIV_W-1:0] div_eff;

    always_comb begin
        div_raw = chan_ctrl[DIV_W-1:0];
        div_eff = (div_raw == '0) ? '1 : div_raw;
        gate    = !chan_ctrl[DIS_POS] && ((pll_ctrl & HOLD_MASK) == '0);
    end

    generate
        if (FIXED_DIV == 1) begin : g_no_post
            assign ratio = RATIO_W'(div_eff);
        end else begin : g_post
            assign ratio = RATIO_W'(div_eff) * RATIO_W'(FIXED_DIV);
        end
    endgenerate
endmodule

// File: rtl/pllch_phase.sv
module pllch_phase #(
    parameter int unsigned RATIO_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               gate,
    input  logic [RATIO_W-1:0] new_ratio,
    output logic               en,
    output logic               lvl,
    output logic               run
);
    typedef struct packed {
        logic [RATIO_W-1:0] cnt;
        logic [RATIO_W-1:0] len;
        logic               first;
        logic               en;
        logic               lvl;
        logic               run;
    } phase_st_t;

    localparam phase_st_t RESET_ST = '{cnt: '0, len: '0, first: 1'b1,
                                       en: 1'b0, lvl: 1'b0, run: 1'b0};

    phase_st_t st_d, st_q;
    logic [RATIO_W-1:0] cur_len;
    logic               term;

    always_comb begin
        st_d    = st_q;
        cur_len = st_q.run ? st_q.len : new_ratio;
        term    = (st_q.cnt == cur_len - 1'b1);
        if (!gate) begin
            st_d     = RESET_ST;
            st_d.len = new_ratio;
        end else begin
            st_d.run = 1'b1;
            if (term) begin
                st_d.cnt   = '0;
                st_d.len   = new_ratio;
                st_d.en    = 1'b1;
                st_d.first = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
                st_d.len = cur_len;
                st_d.en  = 1'b0;
            end
            st_d.lvl = !st_d.first && (st_d.cnt < (st_d.len >> 1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RESET_ST;
        else        st_q <= st_d;
    end

    assign en  = st_q.en;
    assign lvl = st_q.lvl;
    assign run = st_q.run;
endmodule

// File: rtl/pll_chan_div.sv
module pll_chan_div
    import pllch_pkg::*;
#(
    parameter int unsigned DIV_W     = 8,
    parameter int unsigned FIXED_DIV = 2,
    parameter logic [31:0] HOLD_MASK = 32'h0000_0200
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] chan_ctrl,
    input  logic [31:0] pll_ctrl,
    output logic        clk_en,
    output logic        clk_out,
    output logic        running
);
    localparam int unsigned FIX_W   = $clog2(FIXED_DIV + 1);
    localparam int unsigned RATIO_W = DIV_W + FIX_W;

    logic               gate;
    logic [RATIO_W-1:0] ratio;

    pllch_decode #(
        .DIV_W    (DIV_W),
        .FIXED_DIV(FIXED_DIV),
        .HOLD_MASK(HOLD_MASK),
        .RATIO_W  (RATIO_W)
    ) decode_i (
        .chan_ctrl(chan_ctrl),
        .pll_ctrl (pll_ctrl),
        .gate     (gate),
        .ratio    (ratio)
    );

    pllch_phase #(
        .RATIO_W(RATIO_W)
    ) phase_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .gate     (gate),
        .new_ratio(ratio),
        .en       (clk_en),
        .lvl      (clk_out),
        .run      (running)
    );
endmodule

// File: rtl/pll_chan_div_chk.sv
module pll_chan_div_chk #(
    parameter int unsigned DIS_POS   = 8,
    parameter logic [31:0] HOLD_MASK = 32'h0000_0200
) (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] chan_ctrl,
    input logic [31:0] pll_ctrl,
    input logic        clk_en,
    input logic        clk_out,
    input logic        running
);
    // R1/R2: no activity while stopped
    a_r2_quiet_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (!clk_en && !clk_out));

    a_r2_disable_stops: assert property (@(posedge clk) disable iff (!rst_n)
        chan_ctrl[DIS_POS] |=> !running);

    a_r3_hold_stops: assert property (@(posedge clk) disable iff (!rst_n)
        ((pll_ctrl & HOLD_MASK) != 32'h0) |=> !running);

    a_r9_runs_when_open: assert property (@(posedge clk) disable iff (!rst_n)
        (!chan_ctrl[DIS_POS] && ((pll_ctrl & HOLD_MASK) == 32'h0)) |=> running);

    a_r6_rise_with_en: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_out) |-> clk_en);

    a_r7_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> !clk_out);
endmodule

bind pll_chan_div pll_chan_div_chk #(
    .DIS_POS  (DIV_W),
    .HOLD_MASK(HOLD_MASK)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .chan_ctrl(chan_ctrl),
    .pll_ctrl (pll_ctrl),
    .clk_en   (clk_en),
    .clk_out  (clk_out),
    .running  (running)
);

// File: tb/pll_chan_div_tb_top.sv
`timescale 1ns/1ps
module pll_chan_div_tb_top;
    localparam int          FIX  = 3;
    localparam logic [31:0] HOLD = 32'h0000_0200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] chan_ctrl = 32'h0000_0100;
    logic [31:0] pll_ctrl = 32'h0;
    logic        clk_en, clk_out, running;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pll_chan_div #(.DIV_W(8), .FIXED_DIV(FIX), .HOLD_MASK(HOLD)) dut_i (
        .clk(clk), .rst_n(rst_n), .chan_ctrl(chan_ctrl), .pll_ctrl(pll_ctrl),
        .clk_en(clk_en), .clk_out(clk_out), .running(running)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // behavioural reference model
    int m_cnt, m_len;
    bit m_run, m_first, m_en, m_out;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_len = 0; m_run = 0; m_first = 1; m_en = 0; m_out = 0;
        end else begin
            int dv, want, len;
            bit open;
            open = !chan_ctrl[8] && ((pll_ctrl & HOLD) == 0);
            dv   = int'(chan_ctrl[7:0]);
            want = (dv == 0 ? 255 : dv) * FIX;
            if (!open) begin
                m_cnt = 0; m_run = 0; m_first = 1; m_en = 0; m_out = 0;
            end else begin
                len = m_run ? m_len : want;
                if (m_cnt == len - 1) begin
                    m_cnt = 0; m_len = want; m_en = 1; m_first = 0;
                end else begin
                    m_cnt = m_cnt + 1; m_len = len; m_en = 0;
                end
                m_out = !m_first && (m_cnt < m_len / 2);
                m_run = 1;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(clk_en == m_en, "R4 model clk_en", clk_en, m_en);
            chk(clk_out == m_out, "R6 model clk_out", clk_out, m_out);
            chk(running == m_run, "R9 model running", running, m_run);
        end
    end

    // counts negedges until clk_en seen; hi counts clk_out high over those cycles
    task automatic next_en(output int cyc, output int hi);
        cyc = 0; hi = 0;
        do begin
            @(negedge clk);
            cyc++;
            if (clk_out) hi++;
        end while (!clk_en && cyc < 3000);
    endtask

    task automatic quiet_window(input string req);
        int seen;
        seen = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (clk_en || clk_out || running) seen++;
        end
        chk(seen == 0, req, seen, 0);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int c, h;
        repeat (3) @(negedge clk);
        chk(!clk_en && !clk_out && !running, "R1 in reset", {clk_en, clk_out, running}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!clk_en && !clk_out && !running, "R1 stopped after reset", {clk_en, clk_out, running}, 0);

        // start with div 2 -> N = 6
        chan_ctrl = 32'h0000_0002;
        @(negedge clk);
        chk(running == 1'b1, "R9 running after first open edge", running, 1);
        chk(clk_out == 1'b0, "R7 low at start", clk_out, 0);
        next_en(c, h);
        chk(c == 5, "R7 first pulse delay", c + 1, 6);
        chk(h == 1, "R7 level low until first pulse", h, 1);
        next_en(c, h);
        chk(c == 6, "R4 period N=6", c, 6);
        chk(h == 3, "R6 high phase N=6", h, 3);

        // R8: change mid-period to div 3 (N = 9)
        @(negedge clk);
        chan_ctrl = 32'h0000_0003;
        next_en(c, h);
        chk(c == 5, "R8 current period kept", c + 1, 6);
        next_en(c, h);
        chk(c == 9, "R8 new period N=9", c, 9);
        chk(h == 4, "R6 odd high phase N=9", h, 4);

        // odd ratio 3
        chan_ctrl = 32'h0000_0001;
        next_en(c, h);
        next_en(c, h);
        chk(c == 3, "R4 period N=3", c, 3);
        chk(h == 1, "R6 odd high phase N=3", h, 1);

        // R5: zero field -> 255 * 3
        chan_ctrl = 32'h0000_0000;
        next_en(c, h);
        next_en(c, h);
        chk(c == 765, "R5 zero divide is max", c, 765);
        chk(h == 382, "R6 high phase N=765", h, 382);

        // R10: upper bits ignored
        chan_ctrl = 32'hFFFF_FE02;
        next_en(c, h);
        next_en(c, h);
        chk(c == 6, "R10 upper bits ignored", c, 6);

        // R3: unmasked bits of shared word ignored
        pll_ctrl = ~HOLD;
        next_en(c, h);
        next_en(c, h);
        chk(c == 6, "R3 unmasked bits ignored", c, 6);
        chk(running == 1'b1, "R3 still running", running, 1);

        // R3: hold bit stops
        pll_ctrl = HOLD;
        @(negedge clk);
        chk(!running && !clk_en && !clk_out, "R3 hold stops", {clk_en, clk_out, running}, 0);
        quiet_window("R3 no clock while held");
        pll_ctrl = 32'h0;
        @(negedge clk);
        next_en(c, h);
        chk(c == 5, "R7 restart after hold", c + 1, 6);

        // R2: disable bit stops
        chan_ctrl = 32'h0000_0102;
        @(negedge clk);
        chk(!running && !clk_en && !clk_out, "R2 disable stops", {clk_en, clk_out, running}, 0);
        quiet_window("R2 no clock while disabled");
        chan_ctrl = 32'h0000_0002;
        next_en(c, h);
        chk(c == 6, "R9 restart after disable", c, 6);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule